// File: doc/BRIEF.md
# Four-Channel Cycle-Steal DMA Controller

This block moves single bytes between addresses on behalf of up to four request sources, for example a timer that pulses once per compare match. Each channel holds a source address, a destination address, a 16-bit transfer count and a small control word. Every accepted request produces one read of the source byte followed by one write of that byte to the destination, on a single shared bus master port. The bus is released for at least one cycle after each write, so other masters can use it between transfers. When several channels are waiting, a fixed priority picks the next one.

A global control word holds a master enable and two halt flags. One halt flag is set by the `nmi` pin and the other by an error response on the bus. While either halt flag is set, every channel stops and its enable bit is forced to zero, but the partly advanced addresses and count are kept. Software restarts a channel by clearing the flag and then setting that channel's enable again. Clearing the master enable cuts a transfer short at the end of the bus cycle in progress.

Both halt flags and the transfer-end bit are cleared only when software writes 0 to them. Writing 1 leaves them as they are. A channel that starts with a count of zero runs 65536 transfers.

The bus port uses a valid/ready handshake. `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay stable from the cycle `bus_valid` rises until the cycle `bus_ready` is seen high at a rising clock edge. `bus_rdata` and `bus_err` are sampled only in that cycle. The responder may hold `bus_ready` low for as long as it needs.

The configuration port is a plain register bus with single-cycle writes and combinational read data. Addresses are arranged as follows:

- Channel c uses addresses 4c to 4c+3:
  - +0 holds the source address.
  - +1 holds the destination address.
  - +2 holds the count.
  - +3 holds the control word.
- Address 16 holds the global word.

Top module: `dma_ctrl`

## Requirements
- R1: After reset every channel register and the global word read as 0, `bus_valid` is low and `irq` is 0.
- R2: One request pulse on `dreq[c]` produces exactly one read of channel c's source address and then one write of the byte read to its destination address. `bus_valid` is low in the cycle after the write completes.
- R3: Control bit 3 (source) and bit 4 (destination) select increment-by-1; when the bit is 0 that address stays fixed. Each completed write decrements the count by 1, and the count changes in no other way except by a register write.
- R4: A channel set up with count N performs exactly N transfers. The last one sets control bit 1 (transfer end), and `irq[c]` rises when control bit 2 is set. The channel then ignores requests until software writes 0 to bit 1. Control bit 0 is the channel enable.
- R5: Among channels waiting at the same time, channel 0 is served first, then 3, then 2, then 1.
- R6: While `bus_valid` is high and `bus_ready` low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` hold their values.
- R7: A high level on `nmi` sets global bit 1. A transfer already in progress still completes its write and updates its source, destination and count, and the transfer-end bit is not set.
- R8: An error response on a read sets global bit 2. The following write still takes place, and the registers reflect that transfer.
- R9: While global bit 1 or bit 2 is set, no transfer starts, every channel enable reads 0 even if written 1, and requests are dropped rather than kept. After the flag is cleared, only channels whose enable is written 1 again resume, continuing from the kept addresses.
- R10: Writing 0 to global bit 0 (master enable) while a read is in progress lets that read finish and skips the write. Addresses, count, enable and the transfer-end bit stay unchanged, and requests are dropped until the enable is set again.
- R11: Each channel remembers at most one request that arrives while the bus is serving it. Several such pulses merge into one further transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| dreq | input | 4 | Per-channel request pulses |
| nmi | input | 1 | Non-maskable halt input |
| bus_valid | output | 1 | Bus cycle request |
| bus_ready | input | 1 | Bus cycle accepted this edge |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 8 | Write data byte |
| bus_rdata | input | 8 | Read data byte |
| bus_err | input | 1 | Address error response |
| irq | output | 4 | Per-channel end-of-transfer interrupt |

## Verification
The bench targets several halt and timing cases:

- **NMI during a read.** A design that dropped the pending write would lose a byte. One that set the transfer-end bit would report a false completion.
- **Bus error on a read.** The write must still happen and the source must still advance, or a resumed channel would repeat the failing address.
- **Master enable cleared mid-read.** A design that wrote anyway, or advanced the count, would shift later data by one.
- **Requests during a halt.** A design that queued them would fire stale transfers after restart.

Four requests arriving in the same cycle expose a wrong priority order. Repeated pulses during a stalled transfer expose a missing or over-deep request latch. Random channel, mode and count mixes check address stepping and the exact transfer count.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RD = 2'd1, PH_WR = 2'd2} phase_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_TE   = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_SINC = 3;
  localparam int CTL_DINC = 4;
  localparam int CTL_W    = 5;

  localparam int GLB_ME  = 0;
  localparam int GLB_NMI = 1;
  localparam int GLB_AE  = 2;
endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NUM_CH = 4,
  parameter int IW     = 2
) (
  input  logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] grant,
  output logic [IW-1:0]     idx,
  output logic              any
);
  // channel 0 first, then the highest index downward
  always_comb begin
    grant = '0;
    idx   = '0;
    if (pend[0]) begin
      grant[0] = 1'b1;
    end else begin
      for (int k = NUM_CH - 1; k >= 1; k--) begin
        if (pend[k] && grant == '0) begin
          grant[k] = 1'b1;
          idx      = IW'(k);
        end
      end
    end
  end

  assign any = |pend;

  always_comb begin
    p_grant_single_r5: assert ($onehot0(grant));
    p_grant_when_pend_r5: assert ((grant != '0) == (pend != '0));
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel import dma_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_reg,
  input  logic [AW-1:0]    wr_data,
  input  logic             req_in,
  input  logic             glb_ok,
  input  logic             halt,
  input  logic             grant,
  input  logic             done,
  output logic [AW-1:0]    src,
  output logic [AW-1:0]    dst,
  output logic [CW-1:0]    cnt,
  output logic [CTL_W-1:0] ctrl,
  output logic             pend,
  output logic             irq
);
  logic en, te, ie, sinc, dinc, pend_q, run_ok;

  assign run_ok = en & ~te & glb_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      en   <= 1'b0;
      te   <= 1'b0;
      ie   <= 1'b0;
      sinc <= 1'b0;
      dinc <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (wr_reg)
          2'd0: src <= wr_data;
          2'd1: dst <= wr_data;
          2'd2: cnt <= wr_data[CW-1:0];
          default: begin
            en   <= wr_data[CTL_EN];
            te   <= te & wr_data[CTL_TE];
            ie   <= wr_data[CTL_IE];
            sinc <= wr_data[CTL_SINC];
            dinc <= wr_data[CTL_DINC];
          end
        endcase
      end
      if (done) begin
        src <= src + AW'(sinc);
        dst <= dst + AW'(dinc);
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) te <= 1'b1;
      end
      if (halt) en <= 1'b0;
    end
  end

  // one-deep request latch; dropped whenever the channel cannot run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (!run_ok)  pend_q <= 1'b0;
    else if (req_in)   pend_q <= 1'b1;
    else if (grant)    pend_q <= 1'b0;
  end

  assign pend = pend_q & run_ok;
  assign irq  = te & ie;
  assign ctrl = {dinc, sinc, ie, te, en};

  p_te_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te) |-> $past(done));
  p_halt_drops_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !en);
  p_cnt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !(wr_en && wr_reg == 2'd2)) |=> $stable(cnt));
endmodule

// File: rtl/dma_engine.sv
module dma_engine import dma_pkg::*; #(
  parameter int IW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_pend,
  input  logic [IW-1:0] gnt_idx,
  input  logic          me,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          start,
  output logic [IW-1:0] act_idx,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [DW-1:0] wbuf,
  output logic          done,
  output logic          ae_set
);
  phase_e ph;

  assign start     = (ph == PH_IDLE) && any_pend;
  assign bus_valid = (ph != PH_IDLE);
  assign bus_write = (ph == PH_WR);
  assign done      = (ph == PH_WR) && bus_ready;
  assign ae_set    = bus_valid && bus_ready && bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      act_idx <= '0;
      wbuf    <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (any_pend) begin
          act_idx <= gnt_idx;
          ph      <= PH_RD;
        end
        PH_RD: if (bus_ready) begin
          wbuf <= bus_rdata;
          ph   <= me ? PH_WR : PH_IDLE;
        end
        PH_WR: if (bus_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_gap_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_ready) |=> !bus_valid);
  p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> !bus_write);
  p_hold_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) && $stable(act_idx)));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl import dma_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int DW     = 8,
  localparam int RAW   = $clog2(4 * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RAW-1:0]    cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic [NUM_CH-1:0] dreq,
  input  logic              nmi,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_err,
  output logic [NUM_CH-1:0] irq
);
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [AW-1:0]    src_a  [NUM_CH];
  logic [AW-1:0]    dst_a  [NUM_CH];
  logic [CW-1:0]    cnt_a  [NUM_CH];
  logic [CTL_W-1:0] ctrl_a [NUM_CH];
  logic [NUM_CH-1:0] pend, arb_grant, grant, ch_we;
  logic [IW-1:0]    gnt_idx, act_idx;
  logic             any_pend, start, done, ae_set;
  logic             me, nmif, aef, halt, glb_ok, glb_sel;

  assign glb_sel = (cfg_addr == RAW'(4 * NUM_CH));
  assign halt    = nmif | aef;
  assign glb_ok  = me & ~halt;

  // global word: hardware set wins over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me   <= 1'b0;
      nmif <= 1'b0;
      aef  <= 1'b0;
    end else begin
      if (cfg_we && glb_sel) begin
        me   <= cfg_wdata[GLB_ME];
        nmif <= nmif & cfg_wdata[GLB_NMI];
        aef  <= aef & cfg_wdata[GLB_AE];
      end
      if (nmi)    nmif <= 1'b1;
      if (ae_set) aef  <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_we[i] = cfg_we && !glb_sel && (cfg_addr[RAW-1:2] == (RAW-2)'(i));
    dma_channel #(.AW(AW), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ch_we[i]), .wr_reg(cfg_addr[1:0]), .wr_data(cfg_wdata),
      .req_in(dreq[i]), .glb_ok(glb_ok), .halt(halt),
      .grant(grant[i]), .done(done && (act_idx == IW'(i))),
      .src(src_a[i]), .dst(dst_a[i]), .cnt(cnt_a[i]), .ctrl(ctrl_a[i]),
      .pend(pend[i]), .irq(irq[i])
    );
  end

  dma_arbiter #(.NUM_CH(NUM_CH), .IW(IW)) u_arb (
    .pend(pend), .grant(arb_grant), .idx(gnt_idx), .any(any_pend)
  );

  assign grant = arb_grant & {NUM_CH{start}};

  dma_engine #(.IW(IW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .gnt_idx(gnt_idx), .me(me),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .start(start), .act_idx(act_idx), .bus_valid(bus_valid), .bus_write(bus_write),
    .wbuf(bus_wdata), .done(done), .ae_set(ae_set)
  );

  assign bus_addr = bus_write ? dst_a[act_idx] : src_a[act_idx];

  always_comb begin
    cfg_rdata = '0;
    if (glb_sel) begin
      cfg_rdata = AW'({aef, nmif, me});
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfg_addr[RAW-1:2] == (RAW-2)'(c)) begin
          unique case (cfg_addr[1:0])
            2'd0:    cfg_rdata = src_a[c];
            2'd1:    cfg_rdata = dst_a[c];
            2'd2:    cfg_rdata = AW'(cnt_a[c]);
            default: cfg_rdata = AW'(ctrl_a[c]);
          endcase
        end
      end
    end
  end

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_wdata)));
  p_halt_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && halt) |=> !bus_valid);
  p_me_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_ready && !me) |=> !bus_valid);
  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_err) |=> aef);
endmodule

// File: tb/dma_ctrl_bench.sv
module dma_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GLB = 16;
  localparam logic [31:0] EN = 1, TE = 2, IE = 4, SI = 8, DI = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  dreq = '0;
  logic        nmi = 1'b0;
  logic        bus_valid, bus_write;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic        bus_err = 1'b0;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] lg_addr [1024];
  logic        lg_wr   [1024];
  logic [7:0]  lg_data [1024];
  int          nlog = 0;
  bit          hold_rdy = 1'b0, err_en = 1'b0;
  logic [31:0] err_addr = '0;
  bit          hold_bad = 1'b0, gap_bad = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_ctrl u_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .nmi(nmi),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq)
  );

  function automatic logic [7:0] mdata(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] base, input bit inc, input int n);
    return inc ? base + 32'(n) : base;
  endfunction

  // bus responder with random stalls and a log of completed cycles
  initial begin
    bit          was_stall = 1'b0, was_wdone = 1'b0;
    logic [31:0] s_addr;
    logic        s_wr;
    logic [7:0]  s_wd;
    forever begin
      @(negedge clk);
      if (was_wdone && bus_valid) gap_bad = 1'b1;
      if (was_stall && (!bus_valid || bus_addr != s_addr || bus_write != s_wr ||
                        (s_wr && bus_wdata != s_wd))) hold_bad = 1'b1;
      was_wdone = 1'b0;
      was_stall = 1'b0;
      if (bus_valid) begin
        bit go;
        go        = !hold_rdy && ($urandom_range(0, 2) != 0);
        bus_ready = go;
        bus_rdata = mdata(bus_addr);
        bus_err   = go && err_en && (bus_addr == err_addr);
        if (go) begin
          lg_addr[nlog] = bus_addr;
          lg_wr[nlog]   = bus_write;
          lg_data[nlog] = bus_write ? bus_wdata : bus_rdata;
          nlog++;
          was_wdone = bus_write;
        end else begin
          was_stall = 1'b1;
          s_addr = bus_addr;
          s_wr   = bus_write;
          s_wd   = bus_wdata;
        end
      end else begin
        bus_ready = 1'b0;
        bus_err   = 1'b0;
      end
    end
  end

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = 5'(a);
    #1 v = cfg_rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); dreq = m;
    @(negedge clk); dreq = '0;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 12) begin
      @(negedge clk);
      quiet = bus_valid ? 0 : quiet + 1;
    end
  endtask

  task automatic wait_valid();
    while (!bus_valid) @(negedge clk);
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] c, input logic [31:0] ctl);
    wr(ch * 4, s); wr(ch * 4 + 1, d); wr(ch * 4 + 2, c); wr(ch * 4 + 3, ctl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    bit ok;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    ok = 1'b1;
    for (int a = 0; a <= GLB; a++) begin
      rd(a, v);
      if (v != 0) ok = 1'b0;
    end
    eq("R1 registers zero", 32'(ok), 1);
    eq("R1 bus idle and irq", {27'd0, bus_valid, irq}, 0);

    // R2 R3 R4: channel 3, incrementing source, fixed destination, 8 bytes
    wr(GLB, 1);
    prog(3, 32'h100, 32'h8000, 8, EN | IE | SI);
    base = nlog;
    for (int i = 0; i < 8; i++) begin pulse(4'b1000); settle(); end
    eq("R4 exactly eight transfers", 32'(nlog - base), 16);
    ok = 1'b1;
    for (int j = 0; j < 8; j++) begin
      if (lg_wr[base + 2*j] || lg_addr[base + 2*j] != 32'h100 + 32'(j)) ok = 1'b0;
      if (!lg_wr[base + 2*j + 1] || lg_addr[base + 2*j + 1] != 32'h8000 ||
          lg_data[base + 2*j + 1] != mdata(32'h100 + 32'(j))) ok = 1'b0;
    end
    eq("R2 read then write of same byte", 32'(ok), 1);
    rd(12, v); eq("R3 source incremented", v, 32'h108);
    rd(13, v); eq("R3 destination fixed", v, 32'h8000);
    rd(14, v); eq("R4 count at zero", v, 0);
    rd(15, v); eq("R4 transfer end set", v, EN | TE | IE | SI);
    eq("R4 irq raised", 32'(irq), 32'h8);
    base = nlog;
    pulse(4'b1000); settle();
    eq("R4 request ignored after end", 32'(nlog - base), 0);
    wr(15, EN | IE | SI);
    @(negedge clk);
    eq("R4 irq cleared with end bit", 32'(irq), 0);

    // R5 priority with all four waiting together
    for (int c = 0; c < 4; c++) prog(c, 32'h200 + 32'(c * 16), 32'hC000, 1, EN);
    base = nlog;
    pulse(4'b1111); settle();
    eq("R5 eight bus cycles", 32'(nlog - base), 8);
    eq("R5 first channel 0", lg_addr[base], 32'h200);
    eq("R5 second channel 3", lg_addr[base + 2], 32'h230);
    eq("R5 third channel 2", lg_addr[base + 4], 32'h220);
    eq("R5 fourth channel 1", lg_addr[base + 6], 32'h210);

    // R7 R9: NMI during a read
    prog(1, 32'h500, 32'hB000, 4, EN | SI);
    base = nlog;
    hold_rdy = 1'b1;
    pulse(4'b0010);
    wait_valid();
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    hold_rdy = 1'b0;
    settle();
    eq("R7 write completed", 32'(nlog - base), 2);
    eq("R7 written byte", 32'(lg_data[base + 1]), 32'(mdata(32'h500)));
    rd(4, v); eq("R7 source advanced", v, 32'h501);
    rd(6, v); eq("R7 count advanced", v, 3);
    rd(7, v); eq("R7 end not set and enable cleared", v, SI);
    rd(GLB, v); eq("R7 nmi flag", v, 3);
    base = nlog;
    pulse(4'b0010); settle();
    eq("R9 request dropped while halted", 32'(nlog - base), 0);
    wr(7, EN | SI);
    rd(7, v); eq("R9 enable held clear", v, SI);
    wr(GLB, 1);
    rd(GLB, v); eq("R9 flag cleared", v, 1);
    pulse(4'b0010); settle();
    eq("R9 no restart without enable", 32'(nlog - base), 0);
    wr(7, EN | SI);
    pulse(4'b0010); settle();
    eq("R9 resumed transfer", 32'(nlog - base), 2);
    eq("R9 resumed from kept source", lg_addr[base], 32'h501);

    // R8: error on a read
    prog(2, 32'h300, 32'h9000, 3, EN | SI);
    err_addr = 32'h300; err_en = 1'b1;
    base = nlog;
    pulse(4'b0100); settle();
    err_en = 1'b0;
    eq("R8 write after failed read", 32'(nlog - base), 2);
    eq("R8 write target", lg_addr[base + 1], 32'h9000);
    rd(8, v); eq("R8 source advanced", v, 32'h301);
    rd(10, v); eq("R8 count advanced", v, 2);
    rd(11, v); eq("R8 end clear and halted", v, SI);
    rd(GLB, v); eq("R8 error flag", v, 5);
    wr(GLB, 1);

    // R10: master enable cleared during a read
    prog(0, 32'h400, 32'hA000, 5, EN | SI);
    base = nlog;
    hold_rdy = 1'b1;
    pulse(4'b0001);
    wait_valid();
    wr(GLB, 0);
    hold_rdy = 1'b0;
    settle();
    eq("R10 read only", 32'(nlog - base), 1);
    eq("R10 logged cycle is read", 32'(lg_wr[base]), 0);
    rd(0, v); eq("R10 source kept", v, 32'h400);
    rd(2, v); eq("R10 count kept", v, 5);
    rd(3, v); eq("R10 control kept", v, EN | SI);
    base = nlog;
    pulse(4'b0001); settle();
    eq("R10 request dropped while disabled", 32'(nlog - base), 0);
    wr(GLB, 1);
    pulse(4'b0001); settle();
    eq("R10 transfer after re-enable", 32'(nlog - base), 2);
    eq("R10 restarted at kept source", lg_addr[base], 32'h400);

    // R11: extra pulses during a stalled transfer merge
    base = nlog;
    hold_rdy = 1'b1;
    pulse(4'b0001);
    wait_valid();
    pulse(4'b0001);
    pulse(4'b0001);
    hold_rdy = 1'b0;
    settle();
    eq("R11 two transfers", 32'(nlog - base), 4);
    rd(2, v); eq("R11 count", v, 2);

    // random rounds on R3 R4
    for (int r = 0; r < 20; r++) begin
      int ch, c, k, n;
      bit si, di;
      logic [31:0] s0, d0, ctl;
      ch = $urandom_range(0, 3);
      c  = $urandom_range(1, 6);
      k  = $urandom_range(1, 8);
      si = 1'($urandom_range(0, 1));
      di = 1'($urandom_range(0, 1));
      s0 = {16'h0001, 16'($urandom)};
      d0 = {16'h0002, 16'($urandom)};
      ctl = EN | IE | (si ? SI : 0) | (di ? DI : 0);
      prog(ch, s0, d0, 32'(c), ctl);
      base = nlog;
      for (int i = 0; i < k; i++) begin pulse(4'(1 << ch)); settle(); end
      n  = (k < c) ? k : c;
      ok = (nlog - base == 2 * n);
      for (int j = 0; j < n && ok; j++) begin
        if (lg_addr[base + 2*j] != step(s0, si, j) ||
            lg_addr[base + 2*j + 1] != step(d0, di, j) ||
            lg_data[base + 2*j + 1] != mdata(step(s0, si, j))) ok = 1'b0;
      end
      eq("R3 random transfer sequence", 32'(ok), 1);
      rd(ch * 4, v); eq("R3 random source", v, step(s0, si, n));
      rd(ch * 4 + 1, v); eq("R3 random destination", v, step(d0, di, n));
      rd(ch * 4 + 2, v); eq("R4 random count", v, 32'(c - n));
      rd(ch * 4 + 3, v); eq("R4 random end bit", v, ctl | ((n == c) ? TE : 0));
    end

    eq("R6 bus held during stalls", 32'(hold_bad), 0);
    eq("R2 bus released after write", 32'(gap_bad), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule